// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one compare channel of a timer. It holds a programmable compare value, checks it against a counter value supplied from outside on every enabled timer tick, and acts when the two are equal. A match sets a sticky match flag. It can also change a waveform output: toggle it, drive it low, or drive it high. When the channel sets the period in clear-on-match operation, a match also raises a one-cycle request for the counter to reload to zero.

Software can also force a compare. The force applies the selected pin action in the same way a match does, but it does not touch the flag and does not request a counter clear. When software writes the counter, the block notifies the channel through a dedicated input. The channel then ignores a match on the first timer tick that follows, so a freshly loaded count does not cause a false match.

All outputs are registered. An effect shows one clock cycle after the cycle in which its cause is sampled. The counter, the prescaler and the interrupt controller are outside this block.

Top module: `ocu_channel`

## Requirements
- R1: After synchronous reset, `wave_out`, `match_flag` and `clr_req` are 0 and the compare value is 0.
- R2: A write on `cmp_wr` loads `cmp_wdata` into the compare value, which is used from the next cycle. A match is a cycle with `tick`=1 and `cnt_val` equal to the compare value. A match sets `match_flag` in the following cycle.
- R3: A cycle with `tick`=0 never produces a match, even when `cnt_val` equals the compare value.
- R4: On a match, `wave_out` takes its new value in the next cycle according to `act_sel`: 2'b00 leaves it unchanged, 2'b01 inverts it, 2'b10 drives 0, and 2'b11 drives 1.
- R5: A pulse on `force_stb` applies the `act_sel` action to `wave_out` in the next cycle and does not set `match_flag`.
- R6: A forced compare never asserts `clr_req`, even when `ctc_en`=1.
- R7: A match while `ctc_en`=1 asserts `clr_req` for exactly the next cycle. With `ctc_en`=0, `clr_req` stays 0.
- R8: After a cycle with `cnt_wr`=1, the first later cycle with `tick`=1 produces no match, whatever the value of `cnt_val`. Matches are evaluated normally from the tick after that.
- R9: `flag_clr`=1 clears `match_flag` in the next cycle. If a match occurs in the same cycle, the flag is set instead.
- R10: A force and a match in the same cycle apply the action once. With 2'b01 the output inverts a single time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer clock enable; matches are evaluated only when high |
| cnt_val | input | CNT_W | Current counter value |
| cmp_wr | input | 1 | Compare value write strobe |
| cmp_wdata | input | CNT_W | Compare value write data |
| cnt_wr | input | 1 | Notification that software wrote the counter |
| act_sel | input | 2 | Pin action: 00 none, 01 toggle, 10 clear, 11 set |
| ctc_en | input | 1 | This channel defines the period in clear-on-match operation |
| force_stb | input | 1 | Software force-compare strobe |
| flag_clr | input | 1 | Write-one-to-clear for the match flag |
| wave_out | output | 1 | Waveform output pin |
| match_flag | output | 1 | Sticky match flag |
| clr_req | output | 1 | One-cycle counter clear request |

## Verification
The assertions treat each strobe (`force_stb`, `cnt_wr`, `flag_clr`, `cmp_wr`) as a cause that is sampled in one cycle and has its effect in the next. They also assume that `act_sel` and `ctc_en` are stable in the cycle in which a match or force is evaluated. The stimulus changes every input only at the falling edge and raises each strobe for a single cycle. It walks the counter through the compare value with the tick enable held high, held low and toggling. Around counter writes, the tick enable is left low for a few cycles so that the blanking window opens later than the write itself.

// File: rtl/ocu_pkg.sv
package ocu_pkg;
  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } ocu_act_e;

  function automatic logic next_pin(input ocu_act_e act, input logic cur);
    case (act)
      ACT_TOGGLE: next_pin = ~cur;
      ACT_CLEAR:  next_pin = 1'b0;
      ACT_SET:    next_pin = 1'b1;
      default:    next_pin = cur;
    endcase
  endfunction
endpackage

// File: rtl/ocu_cmp_reg.sv
module ocu_cmp_reg #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (wr) q <= wdata;
  end

  // R2
  cmp_load_chk: assert property (@(posedge clk) disable iff (rst)
    wr |=> (q == $past(wdata)));
endmodule

// File: rtl/ocu_match_det.sv
module ocu_match_det #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             cnt_wr,
  output logic             hit
);
  logic blank_q;

  // A counter write arms a mask that is consumed by the next later tick.
  always_ff @(posedge clk) begin
    if (rst)         blank_q <= 1'b0;
    else if (cnt_wr) blank_q <= 1'b1;
    else if (tick)   blank_q <= 1'b0;
  end

  assign hit = tick && !blank_q && (cnt_val == cmp_val);
endmodule

// File: rtl/ocu_wave_ctrl.sv
module ocu_wave_ctrl
  import ocu_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     hit,
  input  logic     force_stb,
  input  ocu_act_e act,
  input  logic     ctc_en,
  input  logic     flag_clr,
  output logic     wave_out,
  output logic     match_flag,
  output logic     clr_req
);
  logic fire;
  assign fire = hit || force_stb;

  always_ff @(posedge clk) begin
    if (rst) begin
      wave_out   <= 1'b0;
      match_flag <= 1'b0;
      clr_req    <= 1'b0;
    end else begin
      if (fire) wave_out <= next_pin(act, wave_out);
      if (hit)           match_flag <= 1'b1;
      else if (flag_clr) match_flag <= 1'b0;
      clr_req <= hit && ctc_en;
    end
  end

  // R2
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    hit |=> match_flag);
  // R5
  force_noflag_chk: assert property (@(posedge clk) disable iff (rst)
    (force_stb && !hit && !match_flag) |=> !match_flag);
  // R6
  force_noclr_chk: assert property (@(posedge clk) disable iff (rst)
    (force_stb && !hit) |=> !clr_req);
  // R7
  clr_only_ctc_chk: assert property (@(posedge clk) disable iff (rst)
    clr_req |-> $past(ctc_en));
  // R4
  pin_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!hit && !force_stb) |=> $stable(wave_out));
endmodule

// File: rtl/ocu_channel.sv
module ocu_channel
  import ocu_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic             cnt_wr,
  input  logic [1:0]       act_sel,
  input  logic             ctc_en,
  input  logic             force_stb,
  input  logic             flag_clr,
  output logic             wave_out,
  output logic             match_flag,
  output logic             clr_req
);
  logic [CNT_W-1:0] cmp_q;
  logic             hit_w;

  ocu_cmp_reg #(.CNT_W(CNT_W)) u_cmp (
    .clk(clk), .rst(rst), .wr(cmp_wr), .wdata(cmp_wdata), .q(cmp_q)
  );

  ocu_match_det #(.CNT_W(CNT_W)) u_det (
    .clk(clk), .rst(rst), .tick(tick), .cnt_val(cnt_val),
    .cmp_val(cmp_q), .cnt_wr(cnt_wr), .hit(hit_w)
  );

  ocu_wave_ctrl u_wave (
    .clk(clk), .rst(rst), .hit(hit_w), .force_stb(force_stb),
    .act(ocu_act_e'(act_sel)), .ctc_en(ctc_en), .flag_clr(flag_clr),
    .wave_out(wave_out), .match_flag(match_flag), .clr_req(clr_req)
  );

  // R8
  blank_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cnt_wr) && tick) |-> !hit_w);
  // R3
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !match_flag) |=> !match_flag);
  // R1
  reset_chk: assert property (@(posedge clk)
    $past(rst) |-> (!wave_out && !match_flag && !clr_req));
endmodule

// File: tb/ocu_channel_tb.sv
module ocu_channel_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tick = 1'b0;
  logic [W-1:0] cnt_val = '0;
  logic         cmp_wr = 1'b0;
  logic [W-1:0] cmp_wdata = '0;
  logic         cnt_wr = 1'b0;
  logic [1:0]   act_sel = 2'b00;
  logic         ctc_en = 1'b0;
  logic         force_stb = 1'b0;
  logic         flag_clr = 1'b0;
  logic         wave_out, match_flag, clr_req;

  always #10 clk = ~clk;

  ocu_channel #(.CNT_W(W)) dut_i (
    .clk(clk), .rst(rst), .tick(tick), .cnt_val(cnt_val),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .cnt_wr(cnt_wr),
    .act_sel(act_sel), .ctc_en(ctc_en), .force_stb(force_stb),
    .flag_clr(flag_clr), .wave_out(wave_out), .match_flag(match_flag),
    .clr_req(clr_req)
  );

  typedef struct {
    logic  wave;
    logic  flag;
    logic  clr;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   finished = 1'b0;

  // Reference state derived from the requirements
  logic [W-1:0] m_cmp = '0;
  logic         m_wave = 1'b0, m_flag = 1'b0, m_blank = 1'b0;

  task automatic drv(input logic tk, input logic [W-1:0] cv,
                     input logic cw, input logic [W-1:0] cd,
                     input logic nw, input logic [1:0] act,
                     input logic ctc, input logic frc, input logic fc,
                     input string tag);
    exp_t e;
    logic hit;
    @(negedge clk);
    tick = tk; cnt_val = cv; cmp_wr = cw; cmp_wdata = cd; cnt_wr = nw;
    act_sel = act; ctc_en = ctc; force_stb = frc; flag_clr = fc;
    hit = tk && !m_blank && (cv == m_cmp);
    if (hit || frc) begin
      case (act)
        2'b01: m_wave = ~m_wave;
        2'b10: m_wave = 1'b0;
        2'b11: m_wave = 1'b1;
        default: m_wave = m_wave;
      endcase
    end
    if (hit) m_flag = 1'b1;
    else if (fc) m_flag = 1'b0;
    if (nw) m_blank = 1'b1;
    else if (tk) m_blank = 1'b0;
    if (cw) m_cmp = cd;
    e.wave = m_wave; e.flag = m_flag; e.clr = hit && ctc; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle(input logic tk, input logic [W-1:0] cv,
                      input logic [1:0] act, input logic ctc, input string tag);
    drv(tk, cv, 1'b0, '0, 1'b0, act, ctc, 1'b0, 1'b0, tag);
  endtask

  // Monitor: compares each registered result shortly after the edge
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_chk++;
      if (wave_out !== e.wave || match_flag !== e.flag || clr_req !== e.clr) begin
        n_bad++;
        $display("FAIL %s: got wave=%b flag=%b clr=%b, expected wave=%b flag=%b clr=%b",
                 e.tag, wave_out, match_flag, clr_req, e.wave, e.flag, e.clr);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state, compare value 0 so count 0 would match only if ticked
    idle(1'b0, 16'd0, 2'b00, 1'b0, "R1");
    idle(1'b0, 16'd7, 2'b00, 1'b0, "R1");
    // R2 / R4 toggle: load 5 and run the counter through it
    drv(1'b0, 16'd0, 1'b1, 16'd5, 1'b0, 2'b01, 1'b0, 1'b0, 1'b0, "R2");
    for (int i = 0; i < 9; i++) idle(1'b1, W'(i), 2'b01, 1'b0, "R2");
    // R9: clear the flag, then clear while matching (set wins)
    drv(1'b0, 16'd9, 1'b0, '0, 1'b0, 2'b01, 1'b0, 1'b0, 1'b1, "R9");
    drv(1'b1, 16'd5, 1'b0, '0, 1'b0, 2'b01, 1'b0, 1'b0, 1'b1, "R9");
    drv(1'b0, 16'd6, 1'b0, '0, 1'b0, 2'b01, 1'b0, 1'b0, 1'b1, "R9");
    // R3: matching count with tick low does nothing
    for (int i = 0; i < 3; i++) idle(1'b0, 16'd5, 2'b11, 1'b1, "R3");
    // R4: clear, set, none actions on matches
    idle(1'b1, 16'd5, 2'b11, 1'b0, "R4");
    idle(1'b1, 16'd5, 2'b10, 1'b0, "R4");
    idle(1'b1, 16'd5, 2'b00, 1'b0, "R4");
    idle(1'b1, 16'd5, 2'b11, 1'b0, "R4");
    idle(1'b1, 16'd5, 2'b00, 1'b0, "R4");
    idle(1'b1, 16'd6, 2'b01, 1'b0, "R4");
    // R5 / R6: forces with flag cleared and ctc enabled
    drv(1'b0, 16'd1, 1'b0, '0, 1'b0, 2'b01, 1'b1, 1'b0, 1'b1, "R5");
    drv(1'b1, 16'd2, 1'b0, '0, 1'b0, 2'b01, 1'b1, 1'b1, 1'b0, "R6");
    drv(1'b0, 16'd2, 1'b0, '0, 1'b0, 2'b10, 1'b1, 1'b1, 1'b0, "R5");
    drv(1'b1, 16'd3, 1'b0, '0, 1'b0, 2'b11, 1'b1, 1'b1, 1'b0, "R6");
    idle(1'b1, 16'd4, 2'b11, 1'b1, "R5");
    // R7: match with ctc gives one-cycle clear request, then without ctc
    idle(1'b1, 16'd5, 2'b01, 1'b1, "R7");
    idle(1'b1, 16'd0, 2'b01, 1'b1, "R7");
    idle(1'b1, 16'd5, 2'b01, 1'b0, "R7");
    idle(1'b1, 16'd6, 2'b01, 1'b0, "R7");
    // R8: counter write, idle ticks, then first tick lands on match -> blanked
    drv(1'b0, 16'd5, 1'b0, '0, 1'b1, 2'b01, 1'b1, 1'b0, 1'b1, "R8");
    idle(1'b0, 16'd5, 2'b01, 1'b1, "R8");
    idle(1'b0, 16'd5, 2'b01, 1'b1, "R8");
    idle(1'b1, 16'd5, 2'b01, 1'b1, "R8");
    idle(1'b1, 16'd5, 2'b01, 1'b1, "R8");
    drv(1'b1, 16'd4, 1'b0, '0, 1'b1, 2'b11, 1'b0, 1'b0, 1'b0, "R8");
    idle(1'b1, 16'd5, 2'b11, 1'b0, "R8");
    idle(1'b1, 16'd5, 2'b10, 1'b0, "R8");
    // R10: force coinciding with a match toggles once
    drv(1'b1, 16'd5, 1'b0, '0, 1'b0, 2'b01, 1'b0, 1'b1, 1'b0, "R10");
    drv(1'b1, 16'd5, 1'b0, '0, 1'b0, 2'b01, 1'b0, 1'b1, 1'b0, "R10");
    // R2: reload compare value at the top of the range
    drv(1'b1, 16'd5, 1'b1, 16'hFFFF, 1'b0, 2'b01, 1'b0, 1'b0, 1'b1, "R2");
    idle(1'b1, 16'd5, 2'b01, 1'b0, "R2");
    idle(1'b1, 16'hFFFF, 2'b01, 1'b1, "R2");
    idle(1'b0, 16'h0000, 2'b01, 1'b0, "R2");
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule